// File: doc/BRIEF.md
# TDMA Frame Period Packer

This block turns a raw slot map for one frame into the final frame layout. Each map entry is either empty or carries a connection id. The id is tagged as downlink or uplink, and consecutive entries with the same tag and id form one train. The packer squeezes the downlink trains toward slot 0 to form the DOWN period. It reserves a radio turnaround gap after them and packs the uplink trains right behind that gap. It then appends the contention slots, a second turnaround and the next frame header. Every slot after that is left empty.

Trains that cannot be placed are cut short or dropped whole, and the block records what it left out. Each such train is listed once, with its id and the number of cells not placed, so the scheduler can serve them first in the next frame. The packer never leaves a piece of a train shorter than its header overhead plus one cell. When the DOWN region is short of room for the gap, the gap therefore takes slots from the last downlink train. That train is dropped entirely if too little of it would remain.

The map is written through an indexed write port and read back through an indexed read port. A start pulse launches the rebuild, which walks the map one entry per clock. The done flag rises only once the whole result map has been written. The period lengths and the deferred list can be read while done is high.

Top module: `tdma_frame_packer`

## Requirements
- R1: After reset, busy and done are low, all period lengths and the deferred count are zero, and every result slot reads as empty (kind 0, id 0).
- R2: An input entry is coded as bit ID_W+1 = occupied, bit ID_W = direction (1 uplink, 0 downlink), and the low ID_W bits = connection id. A result entry is coded as bits ID_W+2..ID_W = kind (0 empty, 1 downlink, 2 uplink, 3 turnaround, 4 contention, 5 header) and the low ID_W bits = id. Map writes are accepted only while busy is low; writes made while busy have no effect on the result.
- R3: Downlink trains are placed from slot 0 in map order with no empty slot between them. They end no later than min(first uplink index, N−CONT−TURN−HDR)−TURN.
- R4: Exactly TURN turnaround slots follow the DOWN period directly.
- R5: A train that does not fully fit is placed with its leading cells only if at least PHI+1 cells can be placed. Otherwise none of it is placed. The cells not placed are deferred. This is also how the turnaround gap takes slots from the last downlink train.
- R6: Downlink trains located after the first uplink slot are moved left into the free space before the gap.
- R7: Uplink trains are packed directly after the gap in map order and end no later than slot N−CONT−TURN−HDR.
- R8: After the UP period come exactly CONT contention slots, then TURN turnaround slots, then HDR header slots. All remaining slots are empty.
- R9: Each train with unplaced cells adds one deferred entry (id, unplaced cell count) in processing order, downlink pass first. The count and the entries can be read after done.
- R10: down_len, up_len and cont_len give the slot counts of the DOWN, UP and contention periods of the last result.
- R11: A start pulse while busy is low begins a rebuild. busy stays high until the result is complete, then done rises and holds, together with the lengths, until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one input map entry |
| wr_idx | input | IW | Input map slot index |
| wr_data | input | ID_W+2 | Input entry (occupied, direction, id) |
| rd_idx | input | IW | Result map slot index |
| rd_data | output | ID_W+3 | Result entry (kind, id) |
| start | input | 1 | Begin a rebuild |
| busy | output | 1 | Rebuild in progress |
| done | output | 1 | Result map valid |
| down_len | output | CW | DOWN period length |
| up_len | output | CW | UP period length |
| cont_len | output | CW | Contention period length |
| def_count | output | CW | Number of deferred entries |
| def_idx | input | IW | Deferred list read index |
| def_id | output | ID_W | Deferred entry connection id |
| def_cells | output | CW | Deferred entry unplaced cell count |

## Verification
On every cycle the assertions check the following: busy and done are never both high; done only rises at the end of a busy rebuild; the period lengths, gaps and header fit inside the frame; the contention count is complete; and the result holds steady while done waits for the next start. The slot-by-slot layout can only be shown by the bench scenarios, as can which trains get cut or dropped and the contents of the deferred list. The scenarios cover a gap that takes slots from the last downlink train, late downlink trains moved forward, uplink overflow, and writes made during a rebuild.

// File: rtl/tdma_pack_pkg.sv
package tdma_pack_pkg;
    typedef enum logic [2:0] {
        K_EMPTY = 3'd0,
        K_DOWN  = 3'd1,
        K_UP    = 3'd2,
        K_GAP   = 3'd3,
        K_CONT  = 3'd4,
        K_HDR   = 3'd5
    } slot_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FIND,
        S_SEEK,
        S_MEAS,
        S_PLACE,
        S_GAP,
        S_TAIL
    } pack_st_e;
endpackage

// File: rtl/tdma_pack_fit.sv
module tdma_pack_fit #(
    parameter int CW  = 6,
    parameter int PHI = 1
) (
    input  logic [CW-1:0] run_len,
    input  logic [CW-1:0] room,
    output logic [CW-1:0] take
);
    localparam logic [CW-1:0] MIN_PART = CW'(PHI + 1);

    always_comb begin
        if (run_len <= room) begin
            take = run_len;
        end else if (room >= MIN_PART) begin
            take = room;
        end else begin
            take = '0;
        end
    end
endmodule

// File: rtl/tdma_pack_tail.sv
module tdma_pack_tail #(
    parameter int CW       = 6,
    parameter int CONT_LEN = 6,
    parameter int TURN     = 1,
    parameter int HDR_LEN  = 5
) (
    input  logic [CW-1:0] rel,
    output logic [2:0]    kind
);
    import tdma_pack_pkg::*;
    localparam logic [CW-1:0] B_CONT = CW'(CONT_LEN);
    localparam logic [CW-1:0] B_GAP  = CW'(CONT_LEN + TURN);
    localparam logic [CW-1:0] B_HDR  = CW'(CONT_LEN + TURN + HDR_LEN);

    always_comb begin
        if (rel < B_CONT)     kind = K_CONT;
        else if (rel < B_GAP) kind = K_GAP;
        else if (rel < B_HDR) kind = K_HDR;
        else                  kind = K_EMPTY;
    end
endmodule

// File: rtl/tdma_frame_packer.sv
module tdma_frame_packer #(
    parameter int N_SLOTS  = 32,
    parameter int ID_W     = 4,
    parameter int PHI      = 1,
    parameter int TURN     = 1,
    parameter int CONT_LEN = 6,
    parameter int HDR_LEN  = 5,
    localparam int CW      = $clog2(N_SLOTS + 1),
    localparam int IW      = $clog2(N_SLOTS),
    localparam int EIN     = ID_W + 2,
    localparam int EOUT    = ID_W + 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [EIN-1:0]  wr_data,
    input  logic [IW-1:0]   rd_idx,
    output logic [EOUT-1:0] rd_data,
    input  logic            start,
    output logic            busy,
    output logic            done,
    output logic [CW-1:0]   down_len,
    output logic [CW-1:0]   up_len,
    output logic [CW-1:0]   cont_len,
    output logic [CW-1:0]   def_count,
    input  logic [IW-1:0]   def_idx,
    output logic [ID_W-1:0] def_id,
    output logic [CW-1:0]   def_cells
);
    import tdma_pack_pkg::*;

    localparam int UP_END_I = N_SLOTS - CONT_LEN - TURN - HDR_LEN;
    localparam logic [CW-1:0] N_C      = CW'(N_SLOTS);
    localparam logic [CW-1:0] UP_END   = CW'(UP_END_I);
    localparam logic [CW-1:0] TURN_C   = CW'(TURN);
    localparam logic [CW-1:0] ONE      = CW'(1);

    typedef struct packed {
        pack_st_e        st;
        logic            busy;
        logic            done;
        logic            pass_up;
        logic [ID_W-1:0] run_id;
        logic [CW-1:0]   scan;
        logic [CW-1:0]   first_up;
        logic [CW-1:0]   limit;
        logic [CW-1:0]   cursor;
        logic [CW-1:0]   up_start;
        logic [CW-1:0]   run_len;
        logic [CW-1:0]   place_cnt;
        logic [CW-1:0]   gcnt;
        logic [CW-1:0]   tcnt;
        logic [CW-1:0]   down_len;
        logic [CW-1:0]   up_len;
        logic [CW-1:0]   cont_len;
        logic [CW-1:0]   def_count;
    } ctl_t;

    ctl_t r_q, r_d;
    logic [EIN-1:0]  src_q   [N_SLOTS];
    logic [EIN-1:0]  src_d   [N_SLOTS];
    logic [EOUT-1:0] dst_q   [N_SLOTS];
    logic [EOUT-1:0] dst_d   [N_SLOTS];
    logic [ID_W-1:0] dfid_q  [N_SLOTS];
    logic [ID_W-1:0] dfid_d  [N_SLOTS];
    logic [CW-1:0]   dfcl_q  [N_SLOTS];
    logic [CW-1:0]   dfcl_d  [N_SLOTS];

    logic [EIN-1:0]  cur;
    logic            scan_ok, match_dir;
    logic [CW-1:0]   take, room, lo_end, lim_down;
    logic [2:0]      tail_kind;

    assign scan_ok   = r_q.scan < N_C;
    assign cur       = src_q[r_q.scan[IW-1:0]];
    assign match_dir = scan_ok && cur[EIN-1] && (cur[ID_W] == r_q.pass_up);
    assign room      = r_q.limit - r_q.cursor;
    assign lo_end    = (r_q.first_up < UP_END) ? r_q.first_up : UP_END;
    assign lim_down  = (lo_end >= TURN_C) ? (lo_end - TURN_C) : '0;

    tdma_pack_fit #(.CW(CW), .PHI(PHI)) u_fit (
        .run_len (r_q.run_len),
        .room    (room),
        .take    (take)
    );

    tdma_pack_tail #(.CW(CW), .CONT_LEN(CONT_LEN), .TURN(TURN), .HDR_LEN(HDR_LEN)) u_tail (
        .rel  (r_q.tcnt),
        .kind (tail_kind)
    );

    always_comb begin
        r_d    = r_q;
        src_d  = src_q;
        dst_d  = dst_q;
        dfid_d = dfid_q;
        dfcl_d = dfcl_q;
        unique case (r_q.st)
            S_IDLE: begin
                if (wr_en) src_d[wr_idx] = wr_data;
                if (start) begin
                    r_d.st        = S_FIND;
                    r_d.busy      = 1'b1;
                    r_d.done      = 1'b0;
                    r_d.scan      = '0;
                    r_d.first_up  = N_C;
                    r_d.down_len  = '0;
                    r_d.up_len    = '0;
                    r_d.cont_len  = '0;
                    r_d.def_count = '0;
                end
            end
            S_FIND: begin
                if (scan_ok) begin
                    if (cur[EIN-1] && cur[ID_W] && r_q.first_up == N_C) r_d.first_up = r_q.scan;
                    r_d.scan = r_q.scan + ONE;
                end else begin
                    r_d.limit   = lim_down;
                    r_d.cursor  = '0;
                    r_d.pass_up = 1'b0;
                    r_d.scan    = '0;
                    r_d.st      = S_SEEK;
                end
            end
            S_SEEK: begin
                if (!scan_ok) begin
                    if (!r_q.pass_up) begin
                        r_d.down_len = r_q.cursor;
                        r_d.gcnt     = '0;
                        r_d.st       = S_GAP;
                    end else begin
                        r_d.up_len = r_q.cursor - r_q.up_start;
                        r_d.tcnt   = '0;
                        r_d.st     = S_TAIL;
                    end
                end else if (match_dir) begin
                    r_d.run_id  = cur[ID_W-1:0];
                    r_d.run_len = '0;
                    r_d.st      = S_MEAS;
                end else begin
                    r_d.scan = r_q.scan + ONE;
                end
            end
            S_MEAS: begin
                if (match_dir && cur[ID_W-1:0] == r_q.run_id) begin
                    r_d.run_len = r_q.run_len + ONE;
                    r_d.scan    = r_q.scan + ONE;
                end else begin
                    if (take != r_q.run_len && r_q.def_count < N_C) begin
                        dfid_d[r_q.def_count[IW-1:0]] = r_q.run_id;
                        dfcl_d[r_q.def_count[IW-1:0]] = r_q.run_len - take;
                        r_d.def_count = r_q.def_count + ONE;
                    end
                    r_d.place_cnt = take;
                    r_d.st        = (take != '0) ? S_PLACE : S_SEEK;
                end
            end
            S_PLACE: begin
                dst_d[r_q.cursor[IW-1:0]] = {(r_q.pass_up ? K_UP : K_DOWN), r_q.run_id};
                r_d.cursor    = r_q.cursor + ONE;
                r_d.place_cnt = r_q.place_cnt - ONE;
                if (r_q.place_cnt == ONE) r_d.st = S_SEEK;
            end
            S_GAP: begin
                dst_d[r_q.cursor[IW-1:0]] = {K_GAP, {ID_W{1'b0}}};
                r_d.cursor = r_q.cursor + ONE;
                r_d.gcnt   = r_q.gcnt + ONE;
                if (r_q.gcnt == TURN_C - ONE) begin
                    r_d.pass_up  = 1'b1;
                    r_d.scan     = '0;
                    r_d.limit    = UP_END;
                    r_d.up_start = r_q.cursor + ONE;
                    r_d.st       = S_SEEK;
                end
            end
            S_TAIL: begin
                if (r_q.cursor == N_C) begin
                    r_d.st   = S_IDLE;
                    r_d.busy = 1'b0;
                    r_d.done = 1'b1;
                end else begin
                    dst_d[r_q.cursor[IW-1:0]] = {tail_kind, {ID_W{1'b0}}};
                    if (tail_kind == K_CONT) r_d.cont_len = r_q.cont_len + ONE;
                    r_d.tcnt   = r_q.tcnt + ONE;
                    r_d.cursor = r_q.cursor + ONE;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
            for (int i = 0; i < N_SLOTS; i++) begin
                src_q[i]  <= '0;
                dst_q[i]  <= '0;
                dfid_q[i] <= '0;
                dfcl_q[i] <= '0;
            end
        end else begin
            r_q    <= r_d;
            src_q  <= src_d;
            dst_q  <= dst_d;
            dfid_q <= dfid_d;
            dfcl_q <= dfcl_d;
        end
    end

    assign rd_data   = dst_q[rd_idx];
    assign busy      = r_q.busy;
    assign done      = r_q.done;
    assign down_len  = r_q.down_len;
    assign up_len    = r_q.up_len;
    assign cont_len  = r_q.cont_len;
    assign def_count = r_q.def_count;
    assign def_id    = dfid_q[def_idx];
    assign def_cells = dfcl_q[def_idx];
endmodule

// File: rtl/tdma_pack_chk.sv
module tdma_pack_chk #(
    parameter int N_SLOTS  = 32,
    parameter int ID_W     = 4,
    parameter int TURN     = 1,
    parameter int CONT_LEN = 6,
    parameter int HDR_LEN  = 5,
    parameter int CW       = 6,
    parameter int EOUT     = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic [CW-1:0]   down_len,
    input logic [CW-1:0]   up_len,
    input logic [CW-1:0]   cont_len,
    input logic [CW-1:0]   def_count,
    input logic [EOUT-1:0] rd_data
);
    localparam int UP_END = N_SLOTS - CONT_LEN - TURN - HDR_LEN;

    a_r11_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    a_r11_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    a_r11_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(down_len) && $stable(up_len) && $stable(def_count)));

    a_r3_down_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(down_len) <= UP_END - TURN));

    a_r7_frame_fits: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(down_len) + TURN + int'(up_len) <= UP_END));

    a_r8_cont_complete: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (int'(cont_len) == CONT_LEN));

    a_r9_def_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(def_count) <= N_SLOTS);

    a_r2_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[EOUT-1:ID_W] <= 3'd5);
endmodule

bind tdma_frame_packer tdma_pack_chk #(
    .N_SLOTS(N_SLOTS), .ID_W(ID_W), .TURN(TURN), .CONT_LEN(CONT_LEN),
    .HDR_LEN(HDR_LEN), .CW(CW), .EOUT(EOUT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .down_len(down_len), .up_len(up_len), .cont_len(cont_len),
    .def_count(def_count), .rd_data(rd_data)
);

// File: tb/tdma_frame_packer_tb.sv
module tdma_frame_packer_tb_top;
    localparam int N = 32;
    localparam int IDW = 4;
    localparam int TP = 1;
    localparam int CL = 6;
    localparam int HL = 5;

    typedef struct packed {
        logic [3:0][16:0] tr;
        logic [5:0] dl;
        logic [5:0] ul;
        logic [5:0] dc;
        logic [3:0] did;
        logic [5:0] dcell;
    } scen_t;

    function automatic logic [16:0] trn(int s, int l, int u, int id);
        return {6'(s), 6'(l), 1'(u), 4'(id)};
    endfunction

    localparam logic [16:0] Z = 17'd0;
    localparam scen_t SCN [6] = '{
        '{tr: {trn(13,2,1,4), trn(8,4,1,3), trn(5,3,0,2), trn(0,3,0,1)}, dl: 6'd6, ul: 6'd6,  dc: 6'd0, did: 4'd0, dcell: 6'd0},
        '{tr: {Z, trn(6,3,1,3), trn(4,2,0,2), trn(0,4,0,1)},            dl: 6'd4, ul: 6'd3,  dc: 6'd1, did: 4'd2, dcell: 6'd2},
        '{tr: {Z, Z, trn(5,2,1,2), trn(0,5,0,1)},                       dl: 6'd4, ul: 6'd2,  dc: 6'd1, did: 4'd1, dcell: 6'd1},
        '{tr: {trn(18,4,0,4), trn(13,5,0,3), trn(10,3,1,2), trn(0,2,0,1)}, dl: 6'd9, ul: 6'd3, dc: 6'd1, did: 4'd4, dcell: 6'd2},
        '{tr: {Z, Z, trn(15,6,1,6), trn(0,15,1,5)},                     dl: 6'd0, ul: 6'd19, dc: 6'd1, did: 4'd6, dcell: 6'd2},
        '{tr: {Z, Z, trn(18,3,1,6), trn(0,18,1,5)},                     dl: 6'd0, ul: 6'd18, dc: 6'd1, did: 4'd6, dcell: 6'd3}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, start = 1'b0;
    logic [4:0] wr_idx = '0, rd_idx = '0, def_idx = '0;
    logic [5:0] wr_data = '0;
    logic [6:0] rd_data;
    logic busy, done;
    logic [5:0] down_len, up_len, cont_len, def_count, def_cells;
    logic [3:0] def_id;

    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    tdma_frame_packer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .start(start), .busy(busy), .done(done),
        .down_len(down_len), .up_len(up_len), .cont_len(cont_len), .def_count(def_count),
        .def_idx(def_idx), .def_id(def_id), .def_cells(def_cells)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put(input int idx, input logic [5:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'(idx); wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_scn(input scen_t s);
        for (int i = 0; i < N; i++) put(i, 6'd0);
        for (int k = 0; k < 4; k++)
            for (int j = 0; j < int'(s.tr[k][10:5]); j++)
                put(int'(s.tr[k][16:11]) + j, {1'b1, s.tr[k][4], s.tr[k][3:0]});
    endtask

    task automatic run_pack;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!done) @(negedge clk);
    endtask

    task automatic slot(input int i, output int kind, output int id);
        rd_idx = 5'(i); #1;
        kind = int'(rd_data[6:4]); id = int'(rd_data[3:0]);
    endtask

    function automatic int exp_kind(input int i, input int dl, input int ul);
        if (i < dl) return 1;                          // R3 downlink
        if (i < dl + TP) return 3;                     // R4 gap
        if (i < dl + TP + ul) return 2;                // R7 uplink
        if (i < dl + TP + ul + CL) return 4;           // R8 contention
        if (i < dl + TP + ul + CL + TP) return 3;      // R8 gap
        if (i < dl + TP + ul + CL + TP + HL) return 5; // R8 header
        return 0;
    endfunction

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL R11: watchdog expired, actual 0 expected 1");
        summary();
    end

    initial begin
        int k, id;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done, "R1 busy/done", int'(busy) + int'(done), 0);
        chk(down_len == 0 && up_len == 0 && cont_len == 0, "R1 lengths", int'(down_len + up_len + cont_len), 0);
        chk(def_count == 0, "R1 def_count", int'(def_count), 0);
        for (int i = 0; i < N; i += 7) begin
            slot(i, k, id);
            chk(k == 0 && id == 0, "R1 empty slot", k * 16 + id, 0);
        end

        // table walk: R3 R4 R5 R6 R7 R8 R9 R10
        for (int s = 0; s < 6; s++) begin
            load_scn(SCN[s]);
            run_pack();
            chk(busy == 1'b0, "R11 busy low at done", int'(busy), 0);
            chk(down_len == SCN[s].dl, "R3 R10 down_len", int'(down_len), int'(SCN[s].dl));
            chk(up_len == SCN[s].ul, "R7 R10 up_len", int'(up_len), int'(SCN[s].ul));
            chk(cont_len == 6'(CL), "R10 cont_len", int'(cont_len), CL);
            chk(def_count == SCN[s].dc, "R5 R9 def_count", int'(def_count), int'(SCN[s].dc));
            if (SCN[s].dc != 0) begin
                def_idx = 5'd0; #1;
                chk(def_id == SCN[s].did, "R9 def_id", int'(def_id), int'(SCN[s].did));
                chk(def_cells == SCN[s].dcell, "R5 R9 def_cells", int'(def_cells), int'(SCN[s].dcell));
            end
            for (int i = 0; i < N; i++) begin
                slot(i, k, id);
                chk(k == exp_kind(i, int'(SCN[s].dl), int'(SCN[s].ul)), "R8 slot kind", k,
                    exp_kind(i, int'(SCN[s].dl), int'(SCN[s].ul)));
            end
            if (s == 0) begin
                slot(0, k, id);  chk(id == 1, "R3 slot0 id", id, 1);
                slot(3, k, id);  chk(id == 2, "R3 slot3 id", id, 2);
                slot(7, k, id);  chk(k == 2 && id == 3, "R7 slot7 id", id, 3);
                slot(11, k, id); chk(k == 2 && id == 4, "R7 slot11 id", id, 4);
            end
            if (s == 2) begin
                slot(3, k, id); chk(k == 1 && id == 1, "R5 trimmed train tail", k * 16 + id, 17);
            end
            if (s == 3) begin
                slot(2, k, id); chk(k == 1 && id == 3, "R6 late train moved", k * 16 + id, 19);
                slot(7, k, id); chk(k == 1 && id == 4, "R6 split head", k * 16 + id, 20);
            end
        end

        // R2 writes while busy are ignored; R11 result stable until next start
        load_scn(SCN[0]);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk); wr_en = 1'b1; wr_idx = 5'd0; wr_data = 6'b11_0111;
        @(negedge clk); wr_en = 1'b0;
        while (!done) @(negedge clk);
        chk(down_len == 6'd6, "R2 write during busy ignored", int'(down_len), 6);
        slot(0, k, id);
        chk(k == 1 && id == 1, "R2 slot0 unchanged", k * 16 + id, 17);
        repeat (5) @(negedge clk);
        chk(done && up_len == 6'd6, "R11 done holds", int'(done), 1);
        summary();
    end
endmodule